// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes a 16-bit command word from a three-wire serial link and turns it into a decoded write request in the system clock domain. The link has a serial clock, a data line and an active-low frame strobe. All three are brought into the system clock through two-flop synchronizers. A data bit is captured on each falling edge of the synchronized serial clock while the frame strobe is low. The system clock must run at least four times faster than the serial clock.

When the sixteenth bit has arrived, the receiver holds the word and raises a one-cycle write strobe. Along with the strobe it presents a channel select, a reference-buffer flag, a two-bit mode and a right-aligned data field. A parameter sets the data resolution to 8, 10 or 12 bits, and the unused low bits of the field are dropped. A frame that is released before its sixteenth bit is discarded without a write. Once a word is complete, the input stage ignores all further clocks and data until the frame strobe goes high and then falls again.

Top module: `scmd_rx`

## Requirements
- R1: The word is 16 bits long and arrives most significant bit first. Each bit is taken on a falling edge of the serial clock. The data level present at a rising edge has no effect.
- R2: Serial clock edges that occur while the frame strobe is high do not shift data and do not produce a write.
- R3: Bit 15 of the word drives `chan_o` (0 = channel A, 1 = channel B). Bit 14 drives `refbuf_o`. Bits 13 and 12 drive `mode_o[1]` and `mode_o[0]` in that order.
- R4: `data_o` equals word bits 11 down to 12-RES_BITS, right-aligned. At 10-bit resolution word bits 1:0 are ignored. At 8-bit resolution word bits 3:0 are ignored.
- R5: `wr_stb_o` is high for exactly one system clock per completed word. It is raised on the sixteenth captured falling edge even while the frame strobe is still low, three system clocks after that edge reaches the pin.
- R6: If the frame strobe rises before the sixteenth falling edge, no write is issued and the outputs keep their previous values. The next frame counts from its first bit again.
- R7: After a complete word, further serial clock edges and data are ignored until the frame strobe has risen and fallen again. A single frame therefore yields at most one write, and that write carries its first sixteen bits.
- R8: After reset, `wr_stb_o`, `chan_o`, `refbuf_o`, `mode_o` and `data_o` are all zero.
- R9: `chan_o`, `refbuf_o`, `mode_o` and `data_o` change only in the cycle where `wr_stb_o` is high, and hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous, idles high |
| sdin_i | input | 1 | Serial data, asynchronous |
| frame_n_i | input | 1 | Active-low frame strobe, asynchronous |
| wr_stb_o | output | 1 | One-cycle write strobe for a completed word |
| chan_o | output | 1 | Channel select from bit 15 |
| refbuf_o | output | 1 | Reference-buffer flag from bit 14 |
| mode_o | output | 2 | Mode field from bits 13:12 |
| data_o | output | RES_BITS | Right-aligned data field |

## Verification
Three receivers with resolutions of 12, 10 and 8 bits share one set of serial inputs, so a single word shows which low bits each width drops. The stimulus contains a normal word, a word left open after its last bit, clock pulses with the frame strobe high, a frame cut off after ten bits, and a thirty-two-bit over-length frame followed by a fresh frame. These cases separate correct framing from counting while idle, from writing on an abort, from a counter that is not cleared, and from wrapping into a second word. The data line is inverted during every clock-high phase, which exposes a receiver that samples on the rising edge.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    localparam int WORD_W      = 16;
    localparam int CNT_W       = $clog2(WORD_W);
    localparam int FIELD_W     = 12;
    localparam int SYNC_STAGES = 2;

    // Bit positions inside the synchronized pin vector
    localparam int PIN_DIN  = 0;
    localparam int PIN_FRM  = 1;
    localparam int PIN_SCLK = 2;
    localparam int PIN_N    = 3;

    // Idle levels: serial clock high, frame strobe high, data low
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b110;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_HOLD  = 2'd2
    } frame_st_e;

    // Layout of a received word, most significant field first
    typedef struct packed {
        logic               chan;
        logic               refbuf;
        logic [1:0]         mode;
        logic [FIELD_W-1:0] field;
    } cmd_word_t;

    // Per-cycle view of the serial link after synchronization
    typedef struct packed {
        logic clk_fall;
        logic frm_fall;
        logic frm_high;
        logic din;
    } ser_evt_t;

    function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] w,
                                                   input logic b);
        return {w[WORD_W-2:0], b};
    endfunction

    function automatic bit res_legal(input int r);
        return (r == 8) || (r == 10) || (r == 12);
    endfunction

endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/scmd_edge.sv
module scmd_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign fall = prev & ~lvl;

    for (genvar b = 0; b < W; b++) begin : g_chk
        // A level that has just fallen cannot fall again on the next cycle
        AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
            fall[b] |=> !fall[b]); // R1
    end

endmodule

// File: rtl/scmd_frame.sv
module scmd_frame
    import scmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ser_evt_t          evt,
    output logic              wr_stb,
    output logic [WORD_W-1:0] word
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    frame_st_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_nxt;

    assign sh_nxt = shift_in(sh, evt.din);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FR_IDLE;
            cnt    <= '0;
            sh     <= '0;
            wr_stb <= 1'b0;
            word   <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                FR_IDLE: begin
                    if (evt.frm_fall) begin
                        state <= FR_SHIFT;
                        cnt   <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (evt.frm_high) begin
                        state <= FR_IDLE;
                        cnt   <= '0;
                    end else if (evt.clk_fall) begin
                        sh <= sh_nxt;
                        if (cnt == LAST_BIT) begin
                            state  <= FR_HOLD;
                            cnt    <= '0;
                            wr_stb <= 1'b1;
                            word   <= sh_nxt;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                FR_HOLD: begin
                    if (evt.frm_fall) begin
                        state <= FR_SHIFT;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= FR_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == FR_SHIFT && evt.frm_high) |=> (state == FR_IDLE && !wr_stb)); // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state != FR_SHIFT) |-> (cnt == '0)); // R6
    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
        (state == FR_HOLD && !evt.frm_fall) |=> (state == FR_HOLD && !wr_stb)); // R7
    AST_STB_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (state == FR_HOLD)); // R7
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R5

endmodule

// File: rtl/scmd_decode.sv
module scmd_decode
    import scmd_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic [WORD_W-1:0]   word,
    output logic                chan,
    output logic                refbuf,
    output logic [1:0]          mode,
    output logic [RES_BITS-1:0] data
);

    localparam int DROP = FIELD_W - RES_BITS;

    cmd_word_t cw;
    assign cw     = cmd_word_t'(word);
    assign chan   = cw.chan;
    assign refbuf = cw.refbuf;
    assign mode   = cw.mode;

    if (DROP == 0) begin : g_full
        assign data = cw.field;
    end else begin : g_trim
        logic unused_low;
        assign data       = cw.field[FIELD_W-1:DROP];
        assign unused_low = ^cw.field[DROP-1:0];
    end

endmodule

// File: rtl/scmd_rx.sv
module scmd_rx
    import scmd_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                sdin_i,
    input  logic                frame_n_i,
    output logic                wr_stb_o,
    output logic                chan_o,
    output logic                refbuf_o,
    output logic [1:0]          mode_o,
    output logic [RES_BITS-1:0] data_o
);

    logic [PIN_N-1:0]  pins_raw;
    logic [PIN_N-1:0]  pins_s;
    logic [1:0]        falls;
    ser_evt_t          evt;
    logic [WORD_W-1:0] word;

    assign pins_raw[PIN_DIN]  = sdin_i;
    assign pins_raw[PIN_FRM]  = frame_n_i;
    assign pins_raw[PIN_SCLK] = sclk_i;

    scmd_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    // falls[1]: serial clock, falls[0]: frame strobe
    scmd_edge #(
        .W       (2),
        .RST_VAL (2'b11)
    ) i_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({pins_s[PIN_SCLK], pins_s[PIN_FRM]}),
        .fall (falls)
    );

    assign evt.clk_fall = falls[1];
    assign evt.frm_fall = falls[0];
    assign evt.frm_high = pins_s[PIN_FRM];
    assign evt.din      = pins_s[PIN_DIN];

    scmd_frame i_frame (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_stb (wr_stb_o),
        .word   (word)
    );

    scmd_decode #(
        .RES_BITS (RES_BITS)
    ) i_decode (
        .word   (word),
        .chan   (chan_o),
        .refbuf (refbuf_o),
        .mode   (mode_o),
        .data   (data_o)
    );

    AST_STB_FRAME_LOW: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> !$past(evt.frm_high)); // R2
    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !wr_stb_o |-> $stable({chan_o, refbuf_o, mode_o, data_o})); // R9

endmodule

// File: tb/test_scmd_rx.sv
module test_scmd_rx;

    logic clk;
    logic rst;
    logic sclk;
    logic sdin;
    logic frm_n;

    logic        stb12, stb10, stb8;
    logic        ch12, ch10, ch8;
    logic        rb12, rb10, rb8;
    logic [1:0]  md12, md10, md8;
    logic [11:0] d12;
    logic [9:0]  d10;
    logic [7:0]  d8;

    int n_run  = 0;
    int n_fail = 0;
    int cnt12  = 0;
    int cnt10  = 0;
    int cnt8   = 0;
    bit done   = 0;

    scmd_rx #(.RES_BITS(12)) i_scmd_rx (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdin_i(sdin), .frame_n_i(frm_n),
        .wr_stb_o(stb12), .chan_o(ch12), .refbuf_o(rb12), .mode_o(md12), .data_o(d12));
    scmd_rx #(.RES_BITS(10)) i_scmd_rx_r10 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdin_i(sdin), .frame_n_i(frm_n),
        .wr_stb_o(stb10), .chan_o(ch10), .refbuf_o(rb10), .mode_o(md10), .data_o(d10));
    scmd_rx #(.RES_BITS(8)) i_scmd_rx_r8 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdin_i(sdin), .frame_n_i(frm_n),
        .wr_stb_o(stb8), .chan_o(ch8), .refbuf_o(rb8), .mode_o(md8), .data_o(d8));

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    function automatic void chk(input string req, input string what,
                                input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    // ---------------- behavioural reference, stepped on every clock ----------
    logic [2:0]  hist[$];    // {sclk, frame, data} per sampled edge, newest first
    int          m_state;    // 0 waiting, 1 collecting, 2 full
    int          m_bits;
    logic [15:0] m_acc;
    logic [15:0] m_word;
    bit          m_stb;

    always @(posedge clk) begin
        if (rst) begin
            hist    = '{3'b110, 3'b110, 3'b110, 3'b110};
            m_state = 0;
            m_bits  = 0;
            m_acc   = '0;
            m_word  = '0;
            m_stb   = 0;
        end else begin
            logic [2:0] now_v, old_v;
            bit clk_f, frm_f;
            hist.push_front({sclk, frm_n, sdin});
            while (hist.size() > 4) void'(hist.pop_back());
            now_v = hist[2];
            old_v = hist[3];
            clk_f = old_v[2] && !now_v[2];
            frm_f = old_v[1] && !now_v[1];
            m_stb = 0;
            if (m_state == 1 && now_v[1]) begin
                m_state = 0;
                m_bits  = 0;
            end else if (m_state == 1 && clk_f) begin
                m_acc  = {m_acc[14:0], now_v[0]};
                m_bits = m_bits + 1;
                if (m_bits == 16) begin
                    m_state = 2;
                    m_bits  = 0;
                    m_stb   = 1;
                    m_word  = m_acc;
                end
            end else if (m_state != 1 && frm_f) begin
                m_state = 1;
                m_bits  = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (stb12) cnt12++;
            if (stb10) cnt10++;
            if (stb8)  cnt8++;
            chk("R5", "strobe 12-bit", int'(stb12), int'(m_stb));
            chk("R5", "strobe 10-bit", int'(stb10), int'(m_stb));
            chk("R5", "strobe 8-bit",  int'(stb8),  int'(m_stb));
            chk("R9", "chan",   int'(ch12), int'(m_word[15]));
            chk("R9", "refbuf", int'(rb12), int'(m_word[14]));
            chk("R9", "mode",   int'(md12), int'(m_word[13:12]));
            chk("R9", "data12", int'(d12),  int'(m_word[11:0]));
            chk("R9", "data10", int'(d10),  int'(m_word[11:2]));
            chk("R9", "data8",  int'(d8),   int'(m_word[11:4]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_frame(input logic [15:0] w, input int nbits, input bit release_frm);
        @(negedge clk);
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 16) ? w[15-i] : 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            sdin = ~sdin;  // a rising-edge sampler would see this level
            repeat (2) @(negedge clk);
        end
        if (release_frm) begin
            frm_n = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic check_fields(input string req, input bit c, input bit r,
                                input int m, input int v12, input int v10, input int v8);
        chk(req, "chan_o",   int'(ch12), int'(c));
        chk(req, "refbuf_o", int'(rb12), int'(r));
        chk(req, "mode_o",   int'(md12), m);
        chk(req, "data 12-bit", int'(d12), v12);
        chk("R4", "data 10-bit", int'(d10), v10);
        chk("R4", "data 8-bit",  int'(d8),  v8);
        chk("R3", "chan 10/8 agree", int'(ch10 & ch8), int'(c));
        chk("R3", "mode 10/8 agree", int'(md10 | md8), m);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int base;
        rst   = 1'b1;
        sclk  = 1'b1;
        sdin  = 1'b0;
        frm_n = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset values
        chk("R8", "wr_stb_o", int'(stb12), 0);
        check_fields("R8", 1'b0, 1'b0, 0, 0, 0, 0);

        // R1 R3 R4: plain word, channel B, mode 2
        base = cnt12;
        send_frame(16'hA5C3, 16, 1'b1);
        chk("R1", "writes for one word", cnt12 - base, 1);
        check_fields("R3", 1'b1, 1'b0, 2, 12'h5C3, 10'h170, 8'h5C);

        // R5: strobe while frame is still low
        base = cnt12;
        send_frame(16'h3FFF, 16, 1'b0);
        chk("R5", "write before frame release", cnt12 - base, 1);
        frm_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5", "single write after release", cnt12 - base, 1);
        check_fields("R3", 1'b0, 1'b0, 3, 12'hFFF, 10'h3FF, 8'hFF);

        // R2: clock pulses with frame high are ignored
        base = cnt12;
        for (int k = 0; k < 6; k++) begin
            sdin = k[0];
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        chk("R2", "no write with frame high", cnt12 - base, 0);
        check_fields("R2", 1'b0, 1'b0, 3, 12'hFFF, 10'h3FF, 8'hFF);

        // R4: low bits dropped at reduced resolution
        send_frame(16'h4001, 16, 1'b1);
        check_fields("R4", 1'b0, 1'b1, 0, 12'h001, 10'h000, 8'h00);

        // R6: abort after ten bits, then a full frame
        base = cnt12;
        send_frame(16'hFFFF, 10, 1'b1);
        chk("R6", "no write on abort", cnt12 - base, 0);
        check_fields("R6", 1'b0, 1'b1, 0, 12'h001, 10'h000, 8'h00);
        send_frame(16'h8ABC, 16, 1'b1);
        chk("R6", "write after abort", cnt12 - base, 1);
        check_fields("R6", 1'b1, 1'b0, 0, 12'hABC, 10'h2AF, 8'hAB);

        // R7: over-length frame, then re-armed frame
        base = cnt12;
        send_frame(16'hC123, 32, 1'b1);
        chk("R7", "one write for 32 clocks", cnt12 - base, 1);
        check_fields("R7", 1'b1, 1'b1, 0, 12'h123, 10'h048, 8'h12);
        send_frame(16'h2468, 16, 1'b1);
        chk("R7", "write after re-arm", cnt12 - base, 2);
        check_fields("R7", 1'b0, 1'b0, 2, 12'h468, 10'h11A, 8'h46);

        chk("R5", "10-bit write count", cnt10, cnt12);
        chk("R5", "8-bit write count",  cnt8,  cnt12);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule